// File: doc/BRIEF.md
# Host message contention controller

This block sits on the host side of a shared-medium transceiver that exchanges characters through a UART-like byte interface. When asked to send a message, it waits until the line-idle flag is high and the required inter-message gap has passed. It then hands the first character of the message to the byte transmitter. That first character is unique to this node. If the transceiver wins access to the medium, it returns the same character on the receive side. The controller then sends the remaining characters of the message from its buffer.

If another node took the medium, the first character that comes back is the other node's character. The controller then becomes a receiver. It forwards that already-captured character as byte 0 of the incoming message and passes on every following received character until the idle flag rises again. If no character comes back within a bounded number of bit times, the attempt is dropped and a failure is reported. Status pulses tell the host whether the attempt was won, lost, failed or completed.

Characters are 8 bits wide by default. A configuration input widens them to 9 bits for both transmission and comparison.

Top module: `msg_contend_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, tx_valid, rcv_valid, won, lost, fail, done and busy are all 0.
- R2: A start request is taken, or held pending, only while the controller is idle. Transmission begins only after a cycle in which idle_line was high. The first character is read from buffer address 0 and held on tx_valid/tx_data until tx_ready.
- R3: If the first received character after the first send matches the sent one under the active width mask, won pulses. Buffer addresses 1 to msg_last are then sent in order. done pulses in the cycle after the character at msg_last is accepted. With msg_last = 0, won and done pulse together.
- R4: If the first received character differs from the sent one, lost pulses. In the same cycle rcv_valid is set with rcv_data equal to that character, and no further characters are sent.
- R5: After a loss, each rx_valid is forwarded one cycle later on rcv_valid/rcv_data. When idle_line rises, the controller returns to idle (busy low) and stops forwarding.
- R6: If no character is received within ECHO_TMO_BITS × BIT_CYC cycles after the first character is accepted, fail pulses and the controller returns to idle without won or lost.
- R7: After done or fail, no new transmission starts until GAP_BITS × BIT_CYC cycles have passed. A start request made during that gap stays pending and is served once the gap ends.
- R8: With cfg_nine = 0, bit 8 of tx_data and rcv_data is 0, and bit 8 of received characters plays no part in the comparison. With cfg_nine = 1, all 9 bits are sent, compared and forwarded.
- R9: A received character that arrives while idle or while the rest of the message is being sent is not forwarded (rcv_valid stays 0).
- R10: won, lost and fail are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nine | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| start | input | 1 | Request to send the buffered message (pulse) |
| msg_last | input | ADDR_W | Buffer index of the last character (length − 1) |
| idle_line | input | 1 | Line-idle flag from the transceiver |
| buf_addr | output | ADDR_W | Message buffer read address |
| buf_data | input | CHAR_W | Message buffer read data, same cycle |
| tx_valid | output | 1 | Character offered to the byte transmitter |
| tx_ready | input | 1 | Byte transmitter accepts the character |
| tx_data | output | CHAR_W | Character to transmit |
| rx_valid | input | 1 | Byte receiver delivers a character |
| rx_data | input | CHAR_W | Received character |
| rcv_valid | output | 1 | Forwarded received character valid |
| rcv_data | output | CHAR_W | Forwarded received character |
| busy | output | 1 | Controller is not idle |
| won | output | 1 | Contention won (pulse) |
| lost | output | 1 | Contention lost (pulse) |
| fail | output | 1 | No echo within timeout (pulse) |
| done | output | 1 | Message fully sent (pulse) |

## Verification
The hardest case to reach is the echo timeout followed directly by the inter-message gap. It needs a first character accepted with no echo for the full window, and then a start request made while the gap timer is still running. The stimulus withholds any receive character after the handshake and counts cycles until fail appears. In that same cycle it issues a new start with the idle flag high, then checks that the transmitter stays quiet for exactly the gap length. Width-mask cases are reached through table vectors that differ from the sent character only in bit 8, once in each width mode.

// File: rtl/msg_contend_pkg.sv
package msg_contend_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_ECHO,
    ST_REST,
    ST_RECV
  } mcc_state_e;

endpackage

// File: rtl/mcc_bit_timer.sv
module mcc_bit_timer #(
  parameter int BIT_CYC       = 16,
  parameter int N_BITS        = 30,
  parameter bit START_EXPIRED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);

  localparam int PRE_W  = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int BITS_W = $clog2(N_BITS + 1);
  localparam logic [PRE_W-1:0]  PRE_TOP  = PRE_W'(BIT_CYC - 1);
  localparam logic [BITS_W-1:0] BITS_END = BITS_W'(N_BITS);
  localparam logic [BITS_W-1:0] BITS_RST = START_EXPIRED ? BITS_END : '0;

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic              cnt_en;

  assign expired = (bits_q == BITS_END);
  assign cnt_en  = restart | (run & ~expired);

  always_comb begin
    pre_d  = pre_q;
    bits_d = bits_q;
    if (restart) begin
      pre_d  = '0;
      bits_d = '0;
    end else if (pre_q == PRE_TOP) begin
      pre_d  = '0;
      bits_d = bits_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      bits_q <= BITS_RST;
    end else if (cnt_en) begin
      pre_q  <= pre_d;
      bits_q <= bits_d;
    end
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= BITS_END) else $error("timer overrun"); // R6

  AST_TMR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired) else $error("timer left expiry"); // R7

endmodule

// File: rtl/mcc_char_mask.sv
module mcc_char_mask #(
  parameter int CHAR_W = 9,
  parameter int BASE_W = 8
) (
  input  logic              wide,
  input  logic [CHAR_W-1:0] a_in,
  input  logic [CHAR_W-1:0] b_in,
  output logic [CHAR_W-1:0] a_out,
  output logic [CHAR_W-1:0] b_out,
  output logic              same
);

  logic [CHAR_W-1:0] mask;

  for (genvar i = 0; i < CHAR_W; i++) begin : g_mask
    if (i < BASE_W) begin : g_base
      assign mask[i] = 1'b1;
    end else begin : g_ext
      assign mask[i] = wide;
    end
  end

  assign a_out = a_in & mask;
  assign b_out = b_in & mask;
  assign same  = (a_out == b_out);

endmodule

// File: rtl/msg_contend_ctrl.sv
module msg_contend_ctrl
  import msg_contend_pkg::*;
#(
  parameter int CHAR_W        = 9,
  parameter int BASE_W        = 8,
  parameter int ADDR_W        = 6,
  parameter int BIT_CYC       = 16,
  parameter int ECHO_TMO_BITS = 30,
  parameter int GAP_BITS      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_nine,
  input  logic              start,
  input  logic [ADDR_W-1:0] msg_last,
  input  logic              idle_line,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [CHAR_W-1:0] buf_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rcv_valid,
  output logic [CHAR_W-1:0] rcv_data,
  output logic              busy,
  output logic              won,
  output logic              lost,
  output logic              fail,
  output logic              done
);

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n_s = rst_s2_q;

  mcc_state_e        st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              pend_q, pend_d;
  logic              idle_q;
  logic              won_d, lost_d, fail_d, done_d, fwd_d;
  logic              gap_restart, gap_ok, tmo_restart, tmo_exp;
  logic              go, idle_rise, echo_same;
  logic [CHAR_W-1:0] rx_m;

  mcc_char_mask #(.CHAR_W(CHAR_W), .BASE_W(BASE_W)) u_mask (
    .wide  (cfg_nine),
    .a_in  (buf_data),
    .b_in  (rx_data),
    .a_out (tx_data),
    .b_out (rx_m),
    .same  (echo_same)
  );

  mcc_bit_timer #(.BIT_CYC(BIT_CYC), .N_BITS(ECHO_TMO_BITS), .START_EXPIRED(1'b0)) u_echo_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .restart (tmo_restart),
    .run     (st_q == ST_ECHO),
    .expired (tmo_exp)
  );

  mcc_bit_timer #(.BIT_CYC(BIT_CYC), .N_BITS(GAP_BITS), .START_EXPIRED(1'b1)) u_gap_tmr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .restart (gap_restart),
    .run     (1'b1),
    .expired (gap_ok)
  );

  assign go          = (start | pend_q) & idle_line & gap_ok;
  assign idle_rise   = idle_line & ~idle_q;
  assign tmo_restart = (st_q == ST_FIRST) & tx_ready;
  assign tx_valid    = (st_q == ST_FIRST) | (st_q == ST_REST);
  assign buf_addr    = idx_q;
  assign busy        = (st_q != ST_IDLE);

  // next-state logic
  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    pend_d      = 1'b0;
    won_d       = 1'b0;
    lost_d      = 1'b0;
    fail_d      = 1'b0;
    done_d      = 1'b0;
    fwd_d       = 1'b0;
    gap_restart = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        idx_d  = '0;
        pend_d = (pend_q | start) & ~go;
        if (go) st_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (tx_ready) st_d = ST_ECHO;
      end
      ST_ECHO: begin
        if (rx_valid) begin
          if (echo_same) begin
            won_d = 1'b1;
            if (msg_last == '0) begin
              done_d      = 1'b1;
              gap_restart = 1'b1;
              st_d        = ST_IDLE;
            end else begin
              idx_d = ADDR_W'(1);
              st_d  = ST_REST;
            end
          end else begin
            lost_d = 1'b1;
            fwd_d  = 1'b1;
            st_d   = ST_RECV;
          end
        end else if (tmo_exp) begin
          fail_d      = 1'b1;
          gap_restart = 1'b1;
          st_d        = ST_IDLE;
        end
      end
      ST_REST: begin
        if (tx_ready) begin
          if (idx_q == msg_last) begin
            done_d      = 1'b1;
            gap_restart = 1'b1;
            idx_d       = '0;
            st_d        = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        fwd_d = rx_valid;
        if (idle_rise) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state and control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      pend_q    <= 1'b0;
      idle_q    <= 1'b1;
      won       <= 1'b0;
      lost      <= 1'b0;
      fail      <= 1'b0;
      done      <= 1'b0;
      rcv_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      pend_q    <= pend_d;
      idle_q    <= idle_line;
      won       <= won_d;
      lost      <= lost_d;
      fail      <= fail_d;
      done      <= done_d;
      rcv_valid <= fwd_d;
    end
  end

  // forwarded data, clock-enabled by the forward strobe
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rcv_data <= '0;
    end else if (fwd_d) begin
      rcv_data <= rx_m;
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({won, lost, fail})) else $error("status overlap"); // R10

  AST_WON_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    won |=> !won) else $error("won held"); // R10

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(tx_valid) && buf_addr == '0) |-> $past(idle_line)) else $error("start without idle"); // R2

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(buf_addr))) else $error("offer dropped"); // R2

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_valid |-> (buf_addr <= msg_last)) else $error("address past end"); // R3

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !won) |-> $past(tx_valid && tx_ready && (buf_addr == msg_last))) else $error("early done"); // R3

  AST_LOST_FWD: assert property (@(posedge clk) disable iff (!rst_n_s)
    lost |-> rcv_valid) else $error("lost without byte 0"); // R4

  AST_RECV_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_RECV) |-> !tx_valid) else $error("sending while receiving"); // R5

endmodule

// File: tb/msg_contend_ctrl_test.sv
module msg_contend_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int BITC       = 4;

  typedef struct packed {
    logic       nine;
    logic [8:0] first;
    logic [8:0] echo;
    logic [5:0] last;
    logic       win;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 9'h05A, 9'h05A, 6'd3, 1'b1},
    '{1'b0, 9'h1A5, 9'h0A5, 6'd2, 1'b1},
    '{1'b1, 9'h1A5, 9'h0A5, 6'd2, 1'b0},
    '{1'b1, 9'h1C3, 9'h1C3, 6'd0, 1'b1},
    '{1'b0, 9'h033, 9'h034, 6'd4, 1'b0},
    '{1'b0, 9'h07E, 9'h17E, 6'd1, 1'b1},
    '{1'b1, 9'h0FF, 9'h0FF, 6'd5, 1'b1},
    '{1'b0, 9'h000, 9'h180, 6'd2, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n, cfg_nine, start, idle_line, tx_ready, rx_valid;
  logic [5:0] msg_last, buf_addr;
  logic [8:0] buf_data, tx_data, rx_data, rcv_data;
  logic       tx_valid, rcv_valid, busy, won, lost, fail, done;
  logic [8:0] mem [0:63];
  int         n_chk = 0;
  int         n_err = 0;
  bit         ended = 0;

  assign buf_data = mem[buf_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_contend_ctrl #(.BIT_CYC(BITC)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_nine(cfg_nine), .start(start),
    .msg_last(msg_last), .idle_line(idle_line), .buf_addr(buf_addr),
    .buf_data(buf_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .busy(busy),
    .won(won), .lost(lost), .fail(fail), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    logic [8:0] msk;
    int         n;
    msk       = v.nine ? 9'h1FF : 9'h0FF;
    cfg_nine  = v.nine;
    msg_last  = v.last;
    mem[0]    = v.first;
    for (int k = 1; k < 64; k++) mem[k] = 9'((vi * 37 + k * 11) ^ 9'h155);
    idle_line = 1'b1;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!tx_valid && n < 120) begin
      @(negedge clk);
      n++;
    end
    chk(tx_valid && tx_data == (v.first & msk), "R2/R8 first char", int'(tx_data), int'(v.first & msk));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready  = 1'b0;
    idle_line = 1'b0;
    chk(!tx_valid, "R2 offer ends on accept", int'(tx_valid), 0);
    rx_valid = 1'b1;
    rx_data  = v.echo;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(won == v.win, "R3/R8 won on echo compare", int'(won), int'(v.win));
    chk(lost == !v.win, "R4/R8 lost on echo compare", int'(lost), int'(!v.win));
    if (v.win) begin
      if (v.last == 0) begin
        chk(done, "R3 single char done with won", int'(done), 1);
      end else begin
        tx_ready = 1'b1;
        rx_valid = 1'b1;
        rx_data  = 9'h1EE;
        for (int k = 1; k <= int'(v.last); k++) begin
          chk(tx_valid && tx_data == (mem[k] & msk), "R3 rest in order", int'(tx_data), int'(mem[k] & msk));
          chk(!rcv_valid, "R9 echo during send not forwarded", int'(rcv_valid), 0);
          chk(!done, "R3 no early done", int'(done), 0);
          if (k == 2) chk(!won, "R10 won single cycle", int'(won), 0);
          @(negedge clk);
        end
        tx_ready = 1'b0;
        rx_valid = 1'b0;
        chk(done && !busy, "R3 done after last", int'(done), 1);
      end
    end else begin
      chk(rcv_valid && rcv_data == (v.echo & msk), "R4 byte 0 forwarded", int'(rcv_data), int'(v.echo & msk));
      chk(!tx_valid, "R4 no further send", int'(tx_valid), 0);
      for (int j = 0; j < 2; j++) begin
        rx_valid = 1'b1;
        rx_data  = 9'h1F0 ^ 9'(j);
        @(negedge clk);
        rx_valid = 1'b0;
        chk(rcv_valid && rcv_data == ((9'h1F0 ^ 9'(j)) & msk), "R5/R8 forward", int'(rcv_data), int'((9'h1F0 ^ 9'(j)) & msk));
      end
      idle_line = 1'b1;
      @(negedge clk);
      chk(!busy, "R5 idle rise ends receive", int'(busy), 0);
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      chk(!rcv_valid, "R5/R9 no forward after return", int'(rcv_valid), 0);
    end
    idle_line = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k;
    rst_n = 1'b0; cfg_nine = 1'b0; start = 1'b0; idle_line = 1'b1;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; msg_last = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !won && !lost && !fail && !done && !rcv_valid, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !busy && !won && !lost && !fail && !done && !rcv_valid, "R1 after release", int'(tx_valid), 0);

    // R9: received character while idle
    rx_valid = 1'b1; rx_data = 9'h011;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(!rcv_valid, "R9 idle rx ignored", int'(rcv_valid), 0);

    // R2: idle flag low holds the request pending
    mem[0] = 9'h0AA; msg_last = '0;
    idle_line = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    for (int i = 0; i < 6; i++) begin
      if (tx_valid) k++;
      @(negedge clk);
    end
    chk(k == 0, "R2 no send while line busy", k, 0);
    idle_line = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_data == 9'h0AA && buf_addr == 0, "R2 pending start served", int'(tx_data), 9'h0AA);

    // R6: no echo, timeout
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    k = 0;
    while (!fail && k < 400) begin
      @(negedge clk);
      k++;
      if (won || lost) chk(0, "R6 no won/lost before timeout", 1, 0);
    end
    chk(k == 30 * BITC + 1, "R6 timeout cycle", k, 30 * BITC + 1);
    chk(fail && !busy, "R6 back to idle", int'(busy), 0);

    // R7: gap after fail, start during gap stays pending
    start = 1'b1;
    for (int m = 1; m <= 12 * BITC + 1; m++) begin
      @(negedge clk);
      start = 1'b0;
      if (m <= 12 * BITC) begin
        if (tx_valid) chk(0, "R7 send inside gap", m, 0);
      end else begin
        chk(tx_valid, "R7 send right after gap", int'(tx_valid), 1);
      end
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    rx_valid = 1'b1; rx_data = 9'h0AA;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(won && done, "R3 single char won and done", int'({won, done}), 3);

    // table of vectors
    for (int i = 0; i < 8; i++) run_vec(VEC[i], i);

    finish_run();
  end

endmodule